// File: doc/BRIEF.md
# Dual-Port Overlay Sink Register

This block is a five-bit output register that both ports of a dual-port memory front end can reach. It occupies one fixed word address. An active-low mode pin decides whether that word belongs to the register or stays part of the ordinary RAM array. Each port has its own decode. When an access lands on the register, the decode raises a hit flag for that port and drops the RAM enable it passes to the array, so the array ignores that cycle.

Each register bit drives an active-high pull-down enable, intended for a board-level open-drain pad. A 1 turns the sink on and pulls the output to ground. A 0 releases it. Writes use the low five data bits and ignore the rest. A read of the register returns the five bits with every upper data bit at zero, and the read does not change the register. Writes take effect at the next clock edge.

Top module: `shared_sink_reg`

## Requirements
- R1: While `rst_n` is low, `sink_en` is 0 (all five sinks off). The register keeps 0 until a write lands on it.
- R2: With `map_sel_n` low, a port write (`*_en`=1, `*_we`=1) to address `REG_ADDR` (default 1) loads data bits 4:0 into `sink_en` at the next rising clock edge. Data bits 15:5 have no effect.
- R3: With `map_sel_n` low, a port read (`*_en`=1, `*_we`=0) of `REG_ADDR` returns `{11'b0, sink_en}` on that port's `*_rdata` in the same cycle, and `sink_en` is unchanged afterwards. In every other case a port's `*_rdata` is 0.
- R4: With `map_sel_n` low, an enabled access to `REG_ADDR` raises that port's `*_hit` and holds its `*_ram_en` at 0.
- R5: With `map_sel_n` high, neither `*_hit` is ever raised and `*_ram_en` equals `*_en` for every address. A write to `REG_ADDR` leaves `sink_en` unchanged.
- R6: An access to any address other than `REG_ADDR` never raises `*_hit`, passes `*_en` to `*_ram_en`, and leaves `sink_en` unchanged.
- R7: If both ports write the register in the same cycle, `sink_en` takes the left port's data bits 4:0.
- R8: A disabled port (`*_en`=0) never raises `*_hit` or `*_ram_en` and never changes `sink_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sel_n | input | 1 | Active-low mode pin: low maps the register over `REG_ADDR` |
| lp_en | input | 1 | Left port access enable |
| lp_we | input | 1 | Left port write (1) or read (0) |
| lp_addr | input | ADDR_W | Left port word address |
| lp_wdata | input | DATA_W | Left port write data |
| lp_rdata | output | DATA_W | Left port register read data |
| lp_hit | output | 1 | Left access is redirected to the register |
| lp_ram_en | output | 1 | Left enable forwarded to the RAM array |
| rp_en | input | 1 | Right port access enable |
| rp_we | input | 1 | Right port write (1) or read (0) |
| rp_addr | input | ADDR_W | Right port word address |
| rp_wdata | input | DATA_W | Right port write data |
| rp_rdata | output | DATA_W | Right port register read data |
| rp_hit | output | 1 | Right access is redirected to the register |
| rp_ram_en | output | 1 | Right enable forwarded to the RAM array |
| sink_en | output | NBITS | Active-high pull-down enables |

## Verification
The bench builds the block with `ADDR_W`=4, `DATA_W`=16, `NBITS`=5 and `REG_ADDR`=1. That shrinks the address space to 16 words, so every address can be swept in both modes, with both directions and from both ports. The bench also writes all 32 register values from each port, each time with a different pattern in the ignored upper bits. Simultaneous writes from both ports are covered, as are reads that follow each write and a reset taken mid-run.

// File: rtl/sinkreg_pkg.sv
package sinkreg_pkg;
  // Port indices; lower index has write priority.
  localparam int NUM_PORTS  = 2;
  localparam int PORT_LEFT  = 0;
  localparam int PORT_RIGHT = 1;

  // Address match against the overlay word, widths handled by caller.
  function automatic logic addr_is(input logic [31:0] addr, input logic [31:0] target);
    return addr == target;
  endfunction
endpackage

// File: rtl/sinkreg_decode.sv
module sinkreg_decode #(
  parameter int ADDR_W   = 13,
  parameter int REG_ADDR = 1
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              map_sel_n,
  output logic              hit,
  output logic              ram_en
);
  import sinkreg_pkg::*;

  logic at_reg;
  assign at_reg = addr_is(32'(addr), 32'(REG_ADDR));

  // Register overlays the word only while the mode pin is low.
  assign hit    = en & at_reg & ~map_sel_n;
  assign ram_en = en & ~hit;
endmodule

// File: rtl/sinkreg_store.sv
module sinkreg_store #(
  parameter int NBITS  = 5,
  parameter int NPORTS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORTS-1:0]            wr_req,
  input  logic [NPORTS-1:0][NBITS-1:0] wr_bits,
  output logic [NBITS-1:0]             state,
  output logic                         wr_any
);
  logic [NBITS-1:0] nxt;

  // Scan from highest index down so the lowest requesting port wins.
  always_comb begin
    nxt = state;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (wr_req[i]) nxt = wr_bits[i];
    end
  end

  assign wr_any = |wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= nxt;
  end
endmodule

// File: rtl/sinkreg_readmux.sv
module sinkreg_readmux #(
  parameter int DATA_W = 16,
  parameter int NBITS  = 5
) (
  input  logic              sel,
  input  logic [NBITS-1:0]  state,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - NBITS;

  assign rdata = sel ? {{PAD_W{1'b0}}, state} : '0;
endmodule

// File: rtl/shared_sink_reg.sv
module shared_sink_reg #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 16,
  parameter int NBITS    = 5,
  parameter int REG_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_sel_n,
  input  logic              lp_en,
  input  logic              lp_we,
  input  logic [ADDR_W-1:0] lp_addr,
  input  logic [DATA_W-1:0] lp_wdata,
  output logic [DATA_W-1:0] lp_rdata,
  output logic              lp_hit,
  output logic              lp_ram_en,
  input  logic              rp_en,
  input  logic              rp_we,
  input  logic [ADDR_W-1:0] rp_addr,
  input  logic [DATA_W-1:0] rp_wdata,
  output logic [DATA_W-1:0] rp_rdata,
  output logic              rp_hit,
  output logic              rp_ram_en,
  output logic [NBITS-1:0]  sink_en
);
  import sinkreg_pkg::*;

  localparam int NP = NUM_PORTS;

  logic [NP-1:0]             p_en, p_we, p_hit, p_ram_en, p_rd_sel;
  logic [NP-1:0][ADDR_W-1:0] p_addr;
  logic [NP-1:0][DATA_W-1:0] p_wdata, p_rdata;
  logic [NP-1:0][NBITS-1:0]  p_bits;
  logic [NP-1:0]             p_wr_req;
  logic                      wr_any;
  logic                      unused_hi_bits;

  assign p_en[PORT_LEFT]     = lp_en;
  assign p_we[PORT_LEFT]     = lp_we;
  assign p_addr[PORT_LEFT]   = lp_addr;
  assign p_wdata[PORT_LEFT]  = lp_wdata;
  assign p_en[PORT_RIGHT]    = rp_en;
  assign p_we[PORT_RIGHT]    = rp_we;
  assign p_addr[PORT_RIGHT]  = rp_addr;
  assign p_wdata[PORT_RIGHT] = rp_wdata;

  for (genvar g = 0; g < NP; g++) begin : g_port
    sinkreg_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
      .en(p_en[g]), .addr(p_addr[g]), .map_sel_n(map_sel_n),
      .hit(p_hit[g]), .ram_en(p_ram_en[g])
    );
    assign p_wr_req[g] = p_hit[g] & p_we[g];
    assign p_rd_sel[g] = p_hit[g] & ~p_we[g];
    assign p_bits[g]   = p_wdata[g][NBITS-1:0];
    sinkreg_readmux #(.DATA_W(DATA_W), .NBITS(NBITS)) u_rd (
      .sel(p_rd_sel[g]), .state(sink_en), .rdata(p_rdata[g])
    );
  end

  sinkreg_store #(.NBITS(NBITS), .NPORTS(NP)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(p_wr_req), .wr_bits(p_bits),
    .state(sink_en), .wr_any(wr_any)
  );

  // Upper write data bits are don't-care by definition.
  assign unused_hi_bits = ^{lp_wdata[DATA_W-1:NBITS], rp_wdata[DATA_W-1:NBITS], wr_any};

  assign lp_rdata  = p_rdata[PORT_LEFT];
  assign lp_hit    = p_hit[PORT_LEFT];
  assign lp_ram_en = p_ram_en[PORT_LEFT];
  assign rp_rdata  = p_rdata[PORT_RIGHT];
  assign rp_hit    = p_hit[PORT_RIGHT];
  assign rp_ram_en = p_ram_en[PORT_RIGHT];
endmodule

// File: rtl/sinkreg_checker.sv
module sinkreg_checker #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 16,
  parameter int NBITS    = 5,
  parameter int REG_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              map_sel_n,
  input logic              lp_en,
  input logic              lp_we,
  input logic [ADDR_W-1:0] lp_addr,
  input logic [DATA_W-1:0] lp_wdata,
  input logic [DATA_W-1:0] lp_rdata,
  input logic              lp_hit,
  input logic              lp_ram_en,
  input logic              rp_en,
  input logic              rp_we,
  input logic [ADDR_W-1:0] rp_addr,
  input logic [DATA_W-1:0] rp_wdata,
  input logic [DATA_W-1:0] rp_rdata,
  input logic              rp_hit,
  input logic              rp_ram_en,
  input logic [NBITS-1:0]  sink_en
);
  logic l_at, r_at;
  assign l_at = (lp_addr == ADDR_W'(REG_ADDR));
  assign r_at = (rp_addr == ADDR_W'(REG_ADDR));

  a_r1_reset_off: assert property (@(posedge clk) !rst_n |=> sink_en == '0);

  a_r2_left_write: assert property (@(posedge clk) disable iff (!rst_n)
    lp_en && lp_we && l_at && !map_sel_n |=> sink_en == $past(lp_wdata[NBITS-1:0]));

  a_r2_right_write: assert property (@(posedge clk) disable iff (!rst_n)
    rp_en && rp_we && r_at && !map_sel_n && !(lp_en && lp_we && l_at)
    |=> sink_en == $past(rp_wdata[NBITS-1:0]));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lp_rdata[DATA_W-1:NBITS] == '0 && rp_rdata[DATA_W-1:NBITS] == '0);

  a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_hit |-> !lp_ram_en) and (rp_hit |-> !rp_ram_en));

  a_r5_mode_high: assert property (@(posedge clk) disable iff (!rst_n)
    map_sel_n |-> !lp_hit && !rp_hit && lp_ram_en == lp_en && rp_ram_en == rp_en);

  a_r6_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_en && lp_we && l_at && !map_sel_n) && !(rp_en && rp_we && r_at && !map_sel_n)
    |=> $stable(sink_en));

  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_en |-> !lp_hit && !lp_ram_en);
endmodule

bind shared_sink_reg sinkreg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBITS(NBITS), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .map_sel_n(map_sel_n),
  .lp_en(lp_en), .lp_we(lp_we), .lp_addr(lp_addr), .lp_wdata(lp_wdata),
  .lp_rdata(lp_rdata), .lp_hit(lp_hit), .lp_ram_en(lp_ram_en),
  .rp_en(rp_en), .rp_we(rp_we), .rp_addr(rp_addr), .rp_wdata(rp_wdata),
  .rp_rdata(rp_rdata), .rp_hit(rp_hit), .rp_ram_en(rp_ram_en),
  .sink_en(sink_en)
);

// File: tb/shared_sink_reg_test.sv
module shared_sink_reg_test;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NB = 5;
  localparam int RA = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_sel_n = 1'b0;
  logic lp_en = 0, lp_we = 0, rp_en = 0, rp_we = 0;
  logic [AW-1:0] lp_addr = '0, rp_addr = '0;
  logic [DW-1:0] lp_wdata = '0, rp_wdata = '0;
  logic [DW-1:0] lp_rdata, rp_rdata;
  logic lp_hit, lp_ram_en, rp_hit, rp_ram_en;
  logic [NB-1:0] sink_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [NB-1:0] model = '0;

  always #4 clk = ~clk;

  shared_sink_reg #(.ADDR_W(AW), .DATA_W(DW), .NBITS(NB), .REG_ADDR(RA)) uut (
    .clk(clk), .rst_n(rst_n), .map_sel_n(map_sel_n),
    .lp_en(lp_en), .lp_we(lp_we), .lp_addr(lp_addr), .lp_wdata(lp_wdata),
    .lp_rdata(lp_rdata), .lp_hit(lp_hit), .lp_ram_en(lp_ram_en),
    .rp_en(rp_en), .rp_we(rp_we), .rp_addr(rp_addr), .rp_wdata(rp_wdata),
    .rp_rdata(rp_rdata), .rp_hit(rp_hit), .rp_ram_en(rp_ram_en),
    .sink_en(sink_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string dec_tag(input logic en, input logic [AW-1:0] a, input logic mode_n);
    if (!en) return "R8 decode";
    if (mode_n) return "R5 decode";
    if (a != AW'(RA)) return "R6 decode";
    return "R4 decode";
  endfunction

  // One bus cycle: drive after negedge, check decode/read, then check state.
  task automatic step(input logic le, input logic lw, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                      input logic re, input logic rw, input logic [AW-1:0] ra, input logic [DW-1:0] rd,
                      input logic mode_n);
    logic lh, rh;
    logic [NB-1:0] nxt;
    string stag;
    @(negedge clk);
    lp_en = le; lp_we = lw; lp_addr = la; lp_wdata = ld;
    rp_en = re; rp_we = rw; rp_addr = ra; rp_wdata = rd;
    map_sel_n = mode_n;
    lh = le && !mode_n && (la == AW'(RA));
    rh = re && !mode_n && (ra == AW'(RA));
    #1;
    chk({dec_tag(le, la, mode_n), " left hit"}, 32'(lp_hit), 32'(lh));
    chk({dec_tag(le, la, mode_n), " left ram_en"}, 32'(lp_ram_en), 32'(le && !lh));
    chk({dec_tag(re, ra, mode_n), " right hit"}, 32'(rp_hit), 32'(rh));
    chk({dec_tag(re, ra, mode_n), " right ram_en"}, 32'(rp_ram_en), 32'(re && !rh));
    chk("R3 left rdata", 32'(lp_rdata), (lh && !lw) ? 32'(model) : 32'd0);
    chk("R3 right rdata", 32'(rp_rdata), (rh && !rw) ? 32'(model) : 32'd0);
    nxt = model;
    if (rh && rw) nxt = rd[NB-1:0];
    if (lh && lw) nxt = ld[NB-1:0];
    if (lh && lw && rh && rw) stag = "R7 state";
    else if ((lh && lw) || (rh && rw)) stag = "R2 state";
    else if (mode_n) stag = "R5 state";
    else stag = "R6 state";
    model = nxt;
    @(negedge clk);
    chk(stag, 32'(sink_en), 32'(model));
    lp_en = 0; rp_en = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 reset sink_en", 32'(sink_en), 0);
    repeat (3) @(negedge clk);
    chk("R1 held reset", 32'(sink_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'(sink_en), 0);

    // Every value from each port, with junk in ignored bits, followed by reads.
    for (int v = 0; v < 32; v++) begin
      logic [DW-1:0] junk;
      junk = DW'((v * 16'h09D3 + 16'h0155) << NB);
      step(1, 1, AW'(RA), junk | DW'(v), 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 0, AW'(RA), 0, 0);
      step(0, 0, 0, 0, 1, 1, AW'(RA), ~junk & ~DW'(v), 0);
      step(1, 0, AW'(RA), 0, 1, 0, AW'(RA), 0, 0);
    end

    // Simultaneous writes: left must win (R7).
    for (int v = 0; v < 32; v++) begin
      step(1, 1, AW'(RA), DW'(v), 1, 1, AW'(RA), DW'(31 - v) | 16'hFFE0, 0);
    end

    // Full address sweep in both modes, reads and writes on both ports.
    step(1, 1, AW'(RA), 16'h0015, 0, 0, 0, 0, 0);
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < (1 << AW); a++) begin
        for (int w = 0; w < 2; w++) begin
          step(1, w[0], AW'(a), DW'(a * 7 + 3), 1, w[0], AW'((a + 5) % (1 << AW)), DW'(a * 11 + 9), m[0]);
          step(0, 1, AW'(RA), 16'h001F, 0, 1, AW'(RA), 16'h001F, 0);
        end
      end
    end

    // Reset mid-run returns all sinks to off.
    step(1, 1, AW'(RA), 16'h001B, 0, 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset", 32'(sink_en), 0);
    model = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 1, 0, AW'(RA), 0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule